// File: doc/BRIEF.md
# Bus-Mapped Countdown Watchdog

This block is a 32-bit down-counter behind an APB slave port, used as a watchdog. It decrements once for each cycle in which an external clock-enable strobe (`tick`) is high, not on every bus clock, so an outside prescaler sets the counting rate. Software writes a reload value, turns the counter on with a single enable bit, and must keep reloading the count before it runs out. When the count reaches zero, a raw status flag is set. The flag, masked by the enable bit, drives the interrupt output.

The count is reloaded from the reload register in four cases:
- software writes the reload register (the written value is taken directly);
- the enable bit rises;
- software writes the interrupt-clear register;
- a tick arrives while the count sits at zero.

A key register blocks register writes until the correct key is written. A build-time parameter selects a sticky variant. In that variant, control writes are ignored once the enable bit is set, and only reset turns the counter off again.

Register word offsets, where `paddr[11:2]` selects the register:

| Offset | Register | Access |
|---|---|---|
| 0x000 | RELOAD | read/write |
| 0x004 | COUNT | read-only |
| 0x008 | CTRL, bit 0 = enable | read/write |
| 0x00C | ACK | write-only |
| 0x010 | RAW, bit 0 | read-only |
| 0x014 | MASKED, bit 0 | read-only |
| 0xC00 | KEY | read/write |

Top module: `apb_wdog_timer`

## Requirements
- R1: After reset the registers read as follows: RELOAD and COUNT read 0xFFFFFFFF; CTRL, RAW, MASKED and KEY read 0; `irq` is low.
- R2: While CTRL bit 0 is 0, COUNT keeps its value across any number of ticks.
- R3: A write to RELOAD (0x000) stores the data. COUNT reads the written value from the next access on, whether or not the counter is enabled.
- R4: A CTRL (0x008) write that sets bit 0 while it was 0 reloads COUNT from RELOAD. Any partial count is discarded.
- R5: While enabled, COUNT drops by one on each cycle with `tick` high, whatever the spacing between ticks.
  - The tick that brings COUNT from 1 to 0 sets RAW (0x010) bit 0.
  - A tick while COUNT is 0 reloads COUNT from RELOAD and does not set RAW.
- R6: A write of any data to ACK (0x00C) clears RAW bit 0 and reloads COUNT from RELOAD in the same access.
- R7: MASKED (0x014) bit 0 reads RAW bit 0 AND CTRL bit 0, and `irq` equals it. Clearing the enable masks a pending flag without clearing RAW.
- R8: With STICKY_EN=1, CTRL writes are ignored once CTRL bit 0 is 1. CTRL keeps reading 1 and counting continues until reset. With STICKY_EN=0, CTRL bit 0 can be cleared by a write.
- R9: Writing 0x1ACCE551 to KEY (0xC00) unlocks the block and any other value locks it. KEY reads 1 when locked and 0 when unlocked, and the block is unlocked after reset. While locked, writes to RELOAD, CTRL and ACK are ignored.
- R10: Every access completes with zero wait states (`pready` high) and `pslverr` low. Reads of unmapped offsets return 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| tick | input | 1 | Count strobe from an external prescaler |
| irq | output | 1 | Watchdog interrupt |

## Verification
The bench goes after the wrap at zero. A design that reloads on the same tick that reaches zero would never show COUNT at 0. A design that raises RAW on the reload tick would fire twice per period.

It checks that the enable rising edge restarts the count. A block missing that edge would resume a stale partial count.

It checks that ACK both clears and reloads. A clear-only design would fire again early.

It runs the plain and sticky variants side by side under the same random access stream and uneven tick spacing, so a CTRL write that leaks through the sticky guard, or a write that leaks past the key, shows up as a diverging COUNT or CTRL readback.

// File: rtl/apb_wdog_timer.sv
module apb_wdog_timer #(
  parameter int          ADDR_W     = 12,
  parameter int          CNT_W      = 32,
  parameter bit          STICKY_EN  = 1'b0,
  parameter logic [31:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              tick,
  output logic              irq
);

  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] IX_RELOAD = IW'(12'h000 >> 2);
  localparam logic [IW-1:0] IX_COUNT  = IW'(12'h004 >> 2);
  localparam logic [IW-1:0] IX_CTRL   = IW'(12'h008 >> 2);
  localparam logic [IW-1:0] IX_ACK    = IW'(12'h00C >> 2);
  localparam logic [IW-1:0] IX_RAW    = IW'(12'h010 >> 2);
  localparam logic [IW-1:0] IX_MASKED = IW'(12'h014 >> 2);
  localparam logic [IW-1:0] IX_KEY    = IW'(12'hC00 >> 2);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload_q, count_q;
  logic             en_q, raw_q, locked_q;

  logic [IW-1:0] idx;
  logic          wr, wr_ok, wr_reload, wr_ctrl, wr_ack, wr_key;
  logic          ctrl_take, en_rise, cnt_step, hits_zero;

  assign idx       = paddr[ADDR_W-1:2];
  assign wr        = psel & penable & pwrite;
  assign wr_ok     = wr & ~locked_q;
  assign wr_reload = wr_ok & (idx == IX_RELOAD);
  assign wr_ctrl   = wr_ok & (idx == IX_CTRL);
  assign wr_ack    = wr_ok & (idx == IX_ACK);
  assign wr_key    = wr & (idx == IX_KEY);

  assign ctrl_take = wr_ctrl & ~(STICKY_EN & en_q);
  assign en_rise   = ctrl_take & pwdata[0] & ~en_q;
  assign cnt_step  = en_q & tick;
  assign hits_zero = cnt_step & (count_q == CNT_ONE) & ~wr_reload & ~wr_ack & ~en_rise;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      reload_q <= '1;
      count_q  <= '1;
      en_q     <= 1'b0;
      raw_q    <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= pwdata[CNT_W-1:0];
      if (ctrl_take) en_q <= pwdata[0];
      if (wr_key)    locked_q <= (pwdata != UNLOCK_KEY);

      if (wr_reload)                count_q <= pwdata[CNT_W-1:0];
      else if (wr_ack || en_rise)   count_q <= reload_q;
      else if (cnt_step)            count_q <= (count_q == '0) ? reload_q : count_q - CNT_ONE;

      if (wr_ack)         raw_q <= 1'b0;
      else if (hits_zero) raw_q <= 1'b1;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (idx)
        IX_RELOAD: prdata = 32'(reload_q);
        IX_COUNT:  prdata = 32'(count_q);
        IX_CTRL:   prdata = {31'b0, en_q};
        IX_RAW:    prdata = {31'b0, raw_q};
        IX_MASKED: prdata = {31'b0, raw_q & en_q};
        IX_KEY:    prdata = {31'b0, locked_q};
        default:   prdata = '0;
      endcase
    end
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irq     = raw_q & en_q;

  p_hold_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (!en_q && !(psel && penable && pwrite)) |=> count_q == $past(count_q));

  p_reload_wr_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && !locked_q && idx == IX_RELOAD)
      |=> (count_q == $past(pwdata[CNT_W-1:0])) && (reload_q == $past(pwdata[CNT_W-1:0])));

  p_enable_edge_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && !locked_q && idx == IX_CTRL && pwdata[0] && !en_q)
      |=> en_q && (count_q == reload_q));

  p_zero_flag_r5: assert property (@(posedge pclk) disable iff (!presetn)
    (en_q && tick && count_q == CNT_ONE && !(psel && penable && pwrite))
      |=> raw_q && (count_q == '0));

  p_wrap_r5: assert property (@(posedge pclk) disable iff (!presetn)
    (en_q && tick && count_q == '0 && !(psel && penable && pwrite))
      |=> (count_q == $past(reload_q)) && (raw_q == $past(raw_q)));

  p_ack_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && !locked_q && idx == IX_ACK)
      |=> !raw_q && (count_q == reload_q));

  p_sticky_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (STICKY_EN && en_q) |=> en_q);

  p_locked_r9: assert property (@(posedge pclk) disable iff (!presetn)
    (locked_q && !(psel && penable && pwrite && idx == IX_KEY))
      |=> $stable(reload_q) && $stable(en_q) && locked_q);

endmodule

// File: tb/apb_wdog_timer_tb.sv
module apb_wdog_timer_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic presetn = 1'b0, psel = 1'b0, penable = 1'b0, pwrite = 1'b0, tick = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] rd_a, rd_b;
  logic rdy_a, rdy_b, err_a, err_b, irq_a, irq_b;

  apb_wdog_timer #(.STICKY_EN(1'b0)) u_dut (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(rd_a), .pready(rdy_a), .pslverr(err_a),
    .tick(tick), .irq(irq_a));

  apb_wdog_timer #(.STICKY_EN(1'b1)) u_dut_stk (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(rd_b), .pready(rdy_b), .pslverr(err_b),
    .tick(tick), .irq(irq_b));

  localparam logic [31:0] KEY = 32'h1ACCE551;
  int n_chk = 0, n_fail = 0;
  logic [31:0] m_load [2];
  logic [31:0] m_val  [2];
  bit          m_en   [2];
  bit          m_raw  [2];
  bit          m_lock;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int i = 0; i < 2; i++) begin
      m_load[i] = '1; m_val[i] = '1; m_en[i] = 0; m_raw[i] = 0;
    end
    m_lock = 0;
  endfunction

  function automatic void m_write(logic [11:0] a, logic [31:0] d);
    if (a == 12'hC00) begin m_lock = (d != KEY); return; end
    if (m_lock) return;
    for (int i = 0; i < 2; i++) begin
      case (a)
        12'h000: begin m_load[i] = d; m_val[i] = d; end
        12'h008: if (!(i == 1 && m_en[i])) begin
                   if (d[0] && !m_en[i]) m_val[i] = m_load[i];
                   m_en[i] = d[0];
                 end
        12'h00C: begin m_raw[i] = 0; m_val[i] = m_load[i]; end
        default: ;
      endcase
    end
  endfunction

  function automatic void m_tick();
    for (int i = 0; i < 2; i++)
      if (m_en[i]) begin
        if (m_val[i] == 0) m_val[i] = m_load[i];
        else begin m_val[i] = m_val[i] - 1; if (m_val[i] == 0) m_raw[i] = 1; end
      end
  endfunction

  task automatic do_reset();
    @(negedge clk); presetn = 1'b0;
    repeat (3) @(negedge clk);
    presetn = 1'b1;
    m_reset();
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    m_write(a, d);
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] va, output logic [31:0] vb);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 va = rd_a; vb = rd_b;
    chk("R10 pready", {30'b0, rdy_a, rdy_b}, 32'h3);
    chk("R10 pslverr", {30'b0, err_a, err_b}, 32'h0);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic do_ticks(int n, int max_gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      m_tick();
      repeat ($urandom_range(max_gap, 0)) @(negedge clk);
    end
  endtask

  task automatic check_model(string tag);
    logic [31:0] a, b;
    bus_read(12'h004, a, b); chk({tag, " R5 count"}, a, m_val[0]); chk({tag, " R5 count stk"}, b, m_val[1]);
    bus_read(12'h000, a, b); chk({tag, " R3 reload"}, a, m_load[0]); chk({tag, " R3 reload stk"}, b, m_load[1]);
    bus_read(12'h008, a, b); chk({tag, " R8 ctrl"}, a, 32'(m_en[0])); chk({tag, " R8 ctrl stk"}, b, 32'(m_en[1]));
    bus_read(12'h010, a, b); chk({tag, " R5 raw"}, a, 32'(m_raw[0])); chk({tag, " R5 raw stk"}, b, 32'(m_raw[1]));
    bus_read(12'h014, a, b); chk({tag, " R7 masked"}, a, 32'(m_raw[0] & m_en[0])); chk({tag, " R7 masked stk"}, b, 32'(m_raw[1] & m_en[1]));
    bus_read(12'hC00, a, b); chk({tag, " R9 key"}, a, 32'(m_lock)); chk({tag, " R9 key stk"}, b, 32'(m_lock));
    #1 chk({tag, " R7 irq"}, {30'b0, irq_a, irq_b}, {30'b0, m_raw[0] & m_en[0], m_raw[1] & m_en[1]});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset values, literal
    bus_read(12'h000, a, b); chk("R1 reload", a, 32'hFFFFFFFF); chk("R1 reload stk", b, 32'hFFFFFFFF);
    bus_read(12'h004, a, b); chk("R1 count", a, 32'hFFFFFFFF);
    bus_read(12'h008, a, b); chk("R1 ctrl", a | b, 32'h0);
    bus_read(12'h010, a, b); chk("R1 raw", a | b, 32'h0);
    check_model("R1");
    // R10 unmapped read
    bus_read(12'h020, a, b); chk("R10 unmapped read", a | b, 32'h0);
    // R2 disabled holds
    do_ticks(10, 2);
    bus_read(12'h004, a, b); chk("R2 hold", a, 32'hFFFFFFFF);
    // R3 reload write while disabled
    bus_write(12'h000, 32'd5);
    bus_read(12'h004, a, b); chk("R3 count=5", a, 32'd5); chk("R3 count=5 stk", b, 32'd5);
    // R5 count down to zero
    bus_write(12'h008, 32'h1);
    do_ticks(4, 3);
    bus_read(12'h004, a, b); chk("R5 count=1", a, 32'd1);
    bus_read(12'h010, a, b); chk("R5 raw not yet", a, 32'd0);
    do_ticks(1, 0);
    bus_read(12'h004, a, b); chk("R5 count=0", a, 32'd0);
    bus_read(12'h010, a, b); chk("R5 raw set", a, 32'd1);
    #1 chk("R7 irq high", {31'b0, irq_a}, 32'd1);
    do_ticks(1, 0);
    bus_read(12'h004, a, b); chk("R5 wrap reload", a, 32'd5);
    check_model("R5");
    // R6 ack with arbitrary data
    do_ticks(2, 4);
    bus_write(12'h00C, 32'hDEADBEEF);
    bus_read(12'h004, a, b); chk("R6 reload on ack", a, 32'd5);
    bus_read(12'h010, a, b); chk("R6 raw cleared", a, 32'd0);
    // R7 / R8 disable while pending
    do_ticks(5, 1);
    bus_write(12'h008, 32'h0);
    bus_read(12'h014, a, b); chk("R7 masked off", a, 32'd0); chk("R8 stk masked on", b, 32'd1);
    bus_read(12'h010, a, b); chk("R7 raw kept", a, 32'd1);
    bus_read(12'h008, a, b); chk("R8 plain ctrl 0", a, 32'd0); chk("R8 sticky ctrl 1", b, 32'd1);
    do_ticks(2, 2);
    bus_read(12'h004, a, b); chk("R2 held at 0", a, 32'd0); chk("R8 stk counts", b, 32'd4);
    // R4 enable edge restarts count
    bus_write(12'h008, 32'h1);
    bus_read(12'h004, a, b); chk("R4 restart", a, 32'd5); chk("R4 stk unaffected", b, 32'd4);
    check_model("R4");
    // R9 lock
    bus_write(12'hC00, 32'h0);
    bus_read(12'hC00, a, b); chk("R9 locked", a, 32'd1);
    bus_write(12'h000, 32'd9);
    bus_read(12'h000, a, b); chk("R9 reload ignored", a, 32'd5);
    bus_write(12'hC00, KEY);
    bus_read(12'hC00, a, b); chk("R9 unlocked", a, 32'd0);
    // R10 unmapped write ignored
    bus_write(12'h018, 32'd7);
    check_model("R10");
    // R8 reset clears sticky enable
    do_reset();
    bus_read(12'h008, a, b); chk("R8 reset clears stk", b, 32'd0);
    check_model("R1b");
    // random phase
    for (int it = 0; it < 80; it++) begin
      int op = $urandom_range(9, 0);
      case (op)
        0, 1: bus_write(12'h000, $urandom_range(25, 0));
        2, 3: bus_write(12'h008, $urandom_range(1, 0));
        4:    bus_write(12'h00C, $urandom);
        5:    bus_write(12'hC00, ($urandom_range(1, 0) == 1) ? KEY : $urandom);
        6:    bus_write(12'h01C, $urandom);
        default: do_ticks($urandom_range(30, 1), $urandom_range(3, 0));
      endcase
      check_model("RND");
    end
    finish_run();
  end
endmodule